// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block produces a divided clock whose high time and low time are set on their own, each in whole input-clock cycles. A single configuration byte carries two 4-bit counts. The lower nibble sets the length of the high phase and the upper nibble sets the length of the low phase. The divide ratio is the sum of the two phase lengths, so it can be any value from 2 to 32. The high share of the period can be any whole-cycle fraction, which means an odd ratio can lean towards either level.

A load strobe captures a new byte into a pending holder. The divider adopts that byte only when the current low phase ends, so a high pulse already under way is never cut short. A bypass control sends the input clock straight to the output, which gives a ratio of 1. While bypass is set, the counter and the output register hold their state so that they use no switching power. When bypass is released, the divider continues from the point where it stopped.

All configuration and mode pins are plain control inputs sampled on the input clock. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `hilo_clk_div`

## Requirements
- R1: Configuration bits [3:0] are the high count H and bits [7:4] are the low count L, each 0 to 15.
- R2: In divide mode the output stays high for exactly H+1 input-clock cycles.
- R3: In divide mode the output stays low for exactly L+1 input-clock cycles, so the period is H+L+2 cycles (ratio 2 to 32).
- R4: With H=0 and L=0 the output is a divide-by-2 clock, high 1 cycle and low 1 cycle.
- R5: Field pairs with the same sum, such as H=3/L=3 and H=2/L=4, give the same period and different high times.
- R6: While bypass is 1 the output equals the input clock, and the counter and divided level do not change; after bypass returns to 0 the phase in progress resumes from where it was frozen.
- R7: A byte taken in by load is applied only at the end of a low phase; the high and low phases already in progress complete with the old counts.
- R8: During reset the output is low and the active counts are zero; the first rising input edge after reset release drives the output high, followed by a divide-by-2 pattern until a load is applied.
- R9: When several loads occur before a low phase ends, the last byte loaded is the one applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_byte | input | 8 | High count in [3:0], low count in [7:4] |
| bypass | input | 1 | 1 forwards clk_in to the output and freezes the divider |
| load | input | 1 | Captures cfg_byte into the pending holder on a rising edge of clk_in |
| clk_out | output | 1 | Divided clock, or clk_in while bypassed |

## Verification
The bench sweeps all 256 field pairs and measures every high and low run at the output. An off-by-one terminal compare, or nibbles swapped in decoding, would show up as runs that are one cycle too long or short, or as mirrored duty cycles. A reload is placed in the middle of a long high phase, and back-to-back loads are also tried. A design that applied bytes immediately would truncate the pulse in progress, and one that kept the first byte would show the wrong counts. Bypass is entered partway through a high phase. A divider that kept counting, or that reset itself during bypass, would return with a wrong remaining high length.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  localparam int FIELD_W = 4;
  localparam int CFG_W   = 2 * FIELD_W;

  typedef struct packed {
    logic [FIELD_W-1:0] lo_cnt;
    logic [FIELD_W-1:0] hi_cnt;
  } hilo_cfg_t;
endpackage

// File: rtl/hilo_cfg_hold.sv
module hilo_cfg_hold
  import hilo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  hilo_cfg_t cfg_in,
  input  logic      apply,
  output hilo_cfg_t active
);
  hilo_cfg_t pend_q;
  logic      pend_vld_q;
  hilo_cfg_t active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      active_q   <= '0;
    end else begin
      if (load) begin
        pend_q     <= cfg_in;
        pend_vld_q <= 1'b1;
      end else if (apply) begin
        pend_vld_q <= 1'b0;
      end
      if (apply && pend_vld_q) begin
        active_q <= pend_q;
      end
    end
  end

  assign active = active_q;

  // R7: active counts only move at a low-phase boundary
  a_r7_hold_between_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(active_q));

  // R9: a load always leaves a pending byte equal to the byte loaded
  a_r9_last_load_kept: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pend_vld_q && pend_q == $past(cfg_in)));
endmodule

// File: rtl/hilo_phase_gen.sv
module hilo_phase_gen #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] hi_n,
  input  logic [CNT_W-1:0] lo_n,
  output logic             div_q,
  output logic             apply
);
  logic [CNT_W-1:0] cnt_q;
  logic             hi_done;
  logic             lo_done;

  assign hi_done = div_q  && (cnt_q == hi_n);
  assign lo_done = !div_q && (cnt_q == lo_n);
  assign apply   = run && lo_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (run) begin
      if (hi_done) begin
        div_q <= 1'b0;
        cnt_q <= '0;
      end else if (lo_done) begin
        div_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: high level persists until the high count is reached
  a_r2_high_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div_q && cnt_q != hi_n) |=> (div_q && cnt_q == $past(cnt_q) + 1'b1));

  // R2: high phase ends with a fresh low phase
  a_r2_high_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div_q && cnt_q == hi_n) |=> (!div_q && cnt_q == '0));

  // R3: low phase ends by starting a high phase
  a_r3_low_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !div_q && cnt_q == lo_n) |=> (div_q && cnt_q == '0));

  // R6: bypass freezes the counting state
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt_q) && $stable(div_q)));
endmodule

// File: rtl/clk_bypass_sel.sv
module clk_bypass_sel (
  input  logic bypass,
  input  logic clk_in,
  input  logic div_in,
  output logic clk_out
);
  always_comb begin
    if (bypass) clk_out = clk_in;
    else        clk_out = div_in;
  end
endmodule

// File: rtl/hilo_clk_div.sv
module hilo_clk_div
  import hilo_pkg::*;
(
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_byte,
  input  logic             bypass,
  input  logic             load,
  output logic             clk_out
);
  hilo_cfg_t cfg_in;
  hilo_cfg_t active;
  logic      apply;
  logic      div_q;
  logic      run;

  assign cfg_in = hilo_cfg_t'(cfg_byte);
  assign run    = !bypass;

  hilo_cfg_hold u_cfg (
    .clk    (clk_in),
    .rst_n  (rst_n),
    .load   (load),
    .cfg_in (cfg_in),
    .apply  (apply),
    .active (active)
  );

  hilo_phase_gen #(.CNT_W(FIELD_W)) u_phase (
    .clk   (clk_in),
    .rst_n (rst_n),
    .run   (run),
    .hi_n  (active.hi_cnt),
    .lo_n  (active.lo_cnt),
    .div_q (div_q),
    .apply (apply)
  );

  clk_bypass_sel u_sel (
    .bypass  (bypass),
    .clk_in  (clk_in),
    .div_in  (div_q),
    .clk_out (clk_out)
  );
endmodule

// File: tb/test_hilo_clk_div.sv
`timescale 1ns/1ps
module test_hilo_clk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic       bypass = 1'b0;
  logic       load = 1'b0;
  logic       clk_out;
  int         errors = 0;
  int         checks = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  hilo_clk_div i_hilo_clk_div (
    .clk_in   (clk),
    .rst_n    (rst_n),
    .cfg_byte (cfg_byte),
    .bypass   (bypass),
    .load     (load),
    .clk_out  (clk_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure_run(output int n);
    logic cur;
    cur = clk_out;
    n = 1;
    forever begin
      @(negedge clk);
      if (clk_out === cur && n < 64) n++;
      else break;
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = clk_out;
    forever begin
      @(negedge clk);
      if (prev === 1'b0 && clk_out === 1'b1) break;
      prev = clk_out;
    end
  endtask

  task automatic load_cfg(input logic [7:0] b);
    cfg_byte = b;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic settle_cfg(input logic [7:0] b);
    load_cfg(b);
    wait_rise();
    wait_rise();
  endtask

  initial begin
    int n;
    int hw;
    int lw;
    // R8: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(clk_out === 1'b0, "R8 low in reset", clk_out, 0);
    end
    rst_n = 1'b1;
    @(negedge clk); check(clk_out === 1'b1, "R8 first high", clk_out, 1);
    @(negedge clk); check(clk_out === 1'b0, "R8 div2 low", clk_out, 0);
    @(negedge clk); check(clk_out === 1'b1, "R8 div2 high", clk_out, 1);

    // R1 R2 R3 R4 R5: full sweep of field pairs
    for (int lo = 0; lo < 16; lo++) begin
      for (int hi = 0; hi < 16; hi++) begin
        settle_cfg({lo[3:0], hi[3:0]});
        measure_run(hw);
        measure_run(lw);
        check(hw == hi + 1, "R2 high width (R1 field [3:0])", hw, hi + 1);
        check(lw == lo + 1, "R3 low width (R1 field [7:4])", lw, lo + 1);
        if (hi == 0 && lo == 0)
          check(hw == 1 && lw == 1, "R4 div2 50%", hw * 10 + lw, 11);
        if ((hi == 3 && lo == 3) || (hi == 2 && lo == 4))
          check(hw + lw == 8 && hw == hi + 1, "R5 same period split", hw * 10 + lw,
                (hi + 1) * 10 + lo + 1);
      end
    end

    // R7: reload mid high phase must not cut it short
    settle_cfg(8'h55);
    @(negedge clk);
    load_cfg(8'h00);
    measure_run(n); check(n == 4, "R7 old high completes", n, 4);
    measure_run(n); check(n == 6, "R7 old low completes", n, 6);
    measure_run(n); check(n == 1, "R7 new high", n, 1);
    measure_run(n); check(n == 1, "R7 new low", n, 1);

    // R9: last of several loads wins
    settle_cfg(8'hFF);
    cfg_byte = 8'h33; load = 1'b1;
    @(negedge clk); cfg_byte = 8'h11;
    @(negedge clk); load = 1'b0;
    measure_run(n);
    measure_run(n); check(n == 16, "R9 old low kept", n, 16);
    measure_run(n); check(n == 2, "R9 last high", n, 2);
    measure_run(n); check(n == 2, "R9 last low", n, 2);

    // R6: bypass forwards clock and freezes the divider
    settle_cfg(8'h44);
    @(negedge clk);
    bypass = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      check(clk_out === 1'b1, "R6 bypass high", clk_out, 1);
      @(negedge clk); #1;
      check(clk_out === 1'b0, "R6 bypass low", clk_out, 0);
    end
    bypass = 1'b0;
    #1;
    measure_run(n); check(n == 4, "R6 resume high remainder", n, 4);
    measure_run(n); check(n == 5, "R6 resume low", n, 5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule